// File: doc/BRIEF.md
# Receive Admission Gate with Unicast Address Filter

This block sits between the PHY-side receive byte stream and the MAC receive FIFO. It decides, frame by frame, whether the bytes may be written into the FIFO. Two software enables gate admission: a link-enable bit that tells the MAC the PHY link may be used, and a receive-enable bit. Both are cleared by every reset, so nothing enters the FIFO until software turns both on. Software can clear the receive-enable bit at any time to stop traffic, for example while queues are being reconfigured.

Admitted frames are written to the FIFO one cycle after they arrive, byte for byte. On the last byte the block raises a keep flag only if the destination address matched. The match is against a 16-entry table of 48-bit unicast addresses, or the frame is broadcast. When the keep flag is low, the FIFO rewinds the frame. Entry 0 of the table is loaded from a nonvolatile-address input on the first clock after reset. The other entries start invalid until software writes them.

A link-change interrupt flags transitions of the PHY link signal while link-enable is set. Two saturating counters record accepted and dropped frames. All control and status goes through a single-cycle word register port.

Top module: `rx_admit_filter`

## Requirements
- R1: While CTRL bit 0 (link enable, word 0x00) is 0, a frame produces no FIFO write and counts as dropped.
- R2: While CTRL bit 1 (receive enable) is 0, a frame produces no FIFO write and counts as dropped.
- R3: CTRL reads 0 after every reset.
- R4: On the first clock after reset, entry 0 takes the value of `nvm_addr_i` and becomes valid. Entries 1 to 15 read as invalid.
- R5: Entry i sits at word 0x20+2i for address bits [31:0] and at word 0x21+2i for address bits [47:32] in data bits [15:0] with the valid flag in bit 31. Both words read back what was written. The first byte on the wire is compared with address bits [47:40]. An entry whose valid flag is clear never matches.
- R6: An admitted frame appears on `wr_*_o` one cycle after each input byte, with the same data, start and last flags. `wr_keep_o` is 1 on the last byte only if the frame has at least 6 bytes, no byte carried `rx_err_i`, and its first 6 bytes equal a valid entry or are all 0xFF.
- R7: The enables are sampled on the start byte and held until the last byte. An enable change in mid-frame neither cuts off an admitted frame nor admits part of a gated frame.
- R8: STATUS (word 0x01) bit 0 shows `link_up_i`. Bit 1, driven onto `irq_o`, is set when `link_up_i` differs from its value one cycle earlier while CTRL bit 0 is 1. It stays set until software writes 1 to bit 1.
- R9: Word 0x02 counts frames admitted with keep=1 and word 0x03 counts all other frames. Each counter moves by one per frame, the cycle after the last write, and saturates at its maximum.
- R10: Bytes that arrive outside a frame (no start byte seen) produce no write and change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | PHY link status |
| nvm_addr_i | input | DA_W | Station address loaded into entry 0 after reset |
| rx_valid_i | input | 1 | Input byte valid |
| rx_data_i | input | 8 | Input byte |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_err_i | input | 1 | Byte received with error |
| wr_valid_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | FIFO write byte |
| wr_sof_o | output | 1 | Written byte starts a frame |
| wr_last_o | output | 1 | Written byte ends a frame |
| wr_keep_o | output | 1 | On last byte: commit (1) or rewind (0) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Link-change interrupt |

## Verification
A stuck or wrongly sampled admission flag shows on `wr_valid_o` within one cycle of the first affected byte. A corrupt address entry or match vector only shows on `wr_keep_o` at the frame's last byte, and in the counters one cycle later. A lost interrupt or link history bit shows on `irq_o` one cycle after the link edge. The bench drives short frames so that each of these windows closes within a few cycles of the stimulus.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [1:0] {
    CSR_CTRL = 2'd0,
    CSR_STAT = 2'd1,
    CSR_ACC  = 2'd2,
    CSR_DROP = 2'd3
  } csr_sel_e;

  localparam int CtrlLinkBit = 0;
  localparam int CtrlRxBit   = 1;
  localparam int StatLinkBit = 0;
  localparam int StatIrqBit  = 1;
  localparam int HiValidBit  = 31;
endpackage

// File: rtl/rxa_addr_table.sv
module rxa_addr_table #(
  parameter int N    = 16,
  parameter int DA_W = 48,
  parameter int AW   = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DA_W-1:0]         nvm_addr_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [31:0]             wdata_i,
  output logic [N-1:0][DA_W-1:0]  tab_o,
  output logic [N-1:0]            val_o,
  output logic [31:0]             rdata_o
);
  import rxa_pkg::*;
  localparam int IW   = $clog2(N);
  localparam int HI_W = DA_W - 32;

  logic [N-1:0][DA_W-1:0] tab_q;
  logic [N-1:0]           val_q;
  logic                   boot_q;
  logic [IW-1:0]          idx;
  logic                   hi, region;

  assign idx    = addr_i[IW:1];
  assign hi     = addr_i[0];
  assign region = addr_i[AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q  <= '0;
      val_q  <= '0;
      boot_q <= 1'b1;
    end else if (boot_q) begin
      tab_q[0] <= nvm_addr_i;
      val_q[0] <= 1'b1;
      boot_q   <= 1'b0;
    end else if (we_i && region) begin
      if (hi) begin
        tab_q[idx][DA_W-1:32] <= wdata_i[HI_W-1:0];
        val_q[idx]            <= wdata_i[HiValidBit];
      end else begin
        tab_q[idx][31:0] <= wdata_i;
      end
    end
  end

  assign tab_o   = tab_q;
  assign val_o   = val_q;
  assign rdata_o = hi ? {val_q[idx], {(31-HI_W){1'b0}}, tab_q[idx][DA_W-1:32]}
                      : tab_q[idx][31:0];

  AST_BOOT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boot_q) |-> (tab_q[0] == $past(nvm_addr_i)) && val_q[0]); // R4
  AST_BOOT_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boot_q) |-> (val_q[N-1:1] == '0)); // R4
endmodule

// File: rtl/rxa_frame.sv
module rxa_frame #(
  parameter int N    = 16,
  parameter int DA_W = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [N-1:0][DA_W-1:0]  tab_i,
  input  logic [N-1:0]            val_i,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_data_i,
  input  logic                    rx_sof_i,
  input  logic                    rx_eof_i,
  input  logic                    rx_err_i,
  output logic                    wr_valid_o,
  output logic [7:0]              wr_data_o,
  output logic                    wr_sof_o,
  output logic                    wr_last_o,
  output logic                    wr_keep_o,
  output logic                    done_o,
  output logic                    done_keep_o
);
  localparam int DA_LEN = DA_W / 8;
  localparam int CW     = $clog2(DA_LEN + 1);

  logic          in_frame_q, admit_q, bc_q, err_q;
  logic [CW-1:0] cnt_q;
  logic [N-1:0]  hit_q;

  logic          act, adm, in_da, bc_n, err_n, keep;
  logic [CW-1:0] cnt_c, cnt_n, byte_idx;
  logic [N-1:0]  hit_b, hit_n;

  assign act      = rx_valid_i && (rx_sof_i || in_frame_q);
  assign adm      = rx_sof_i ? en_i : admit_q;  // sampled once per frame
  assign cnt_c    = rx_sof_i ? '0 : cnt_q;
  assign hit_b    = rx_sof_i ? val_i : hit_q;
  assign in_da    = cnt_c < CW'(DA_LEN);
  assign byte_idx = in_da ? CW'(DA_LEN - 1) - cnt_c : '0;
  assign cnt_n    = in_da ? cnt_c + CW'(1) : cnt_c;
  assign bc_n     = (rx_sof_i || bc_q) && (!in_da || rx_data_i == 8'hFF);
  assign err_n    = (!rx_sof_i && err_q) || rx_err_i;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_n[g] = hit_b[g] &&
      (!in_da || rx_data_i == tab_i[g][{byte_idx, 3'b000} +: 8]);
  end

  assign keep = (cnt_n == CW'(DA_LEN)) && !err_n && ((|hit_n) || bc_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q  <= 1'b0;
      admit_q     <= 1'b0;
      cnt_q       <= '0;
      hit_q       <= '0;
      bc_q        <= 1'b0;
      err_q       <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_data_o   <= '0;
      wr_sof_o    <= 1'b0;
      wr_last_o   <= 1'b0;
      wr_keep_o   <= 1'b0;
      done_o      <= 1'b0;
      done_keep_o <= 1'b0;
    end else begin
      if (act) begin
        in_frame_q <= !rx_eof_i;
        admit_q    <= adm;
        cnt_q      <= cnt_n;
        hit_q      <= hit_n;
        bc_q       <= bc_n;
        err_q      <= err_n;
      end
      wr_valid_o  <= act && adm;
      wr_data_o   <= rx_data_i;
      wr_sof_o    <= rx_sof_i;
      wr_last_o   <= rx_eof_i;
      wr_keep_o   <= rx_eof_i && keep;
      done_o      <= act && rx_eof_i;
      done_keep_o <= act && rx_eof_i && adm && keep;
    end
  end

  AST_HOLD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_sof_i && in_frame_q && admit_q) |=> wr_valid_o); // R7
  AST_HOLD_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_sof_i && in_frame_q && !admit_q) |=> !wr_valid_o); // R7
  AST_STRAY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_sof_i && !in_frame_q) |=> !wr_valid_o && !done_o); // R10
  AST_KEEP_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_keep_o |-> wr_valid_o && wr_last_o && wr_keep_o); // R6
endmodule

// File: rtl/rxa_csr.sv
module rxa_csr #(
  parameter int CNT_W = 16,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    wdata_i,
  input  logic [31:0]   tab_rdata_i,
  input  logic          link_up_i,
  input  logic          done_i,
  input  logic          done_keep_i,
  output logic          link_en_o,
  output logic          rx_en_o,
  output logic          irq_o,
  output logic [31:0]   rdata_o
);
  import rxa_pkg::*;

  logic             link_q, irq_q;
  logic [CNT_W-1:0] acc_q, drop_q;
  logic             csr_hit, ctrl_we, stat_clr, link_evt;
  csr_sel_e         sel;

  assign sel      = csr_sel_e'(addr_i[1:0]);
  assign csr_hit  = (addr_i[AW-1:2] == '0);
  assign ctrl_we  = we_i && csr_hit && (sel == CSR_CTRL);
  assign stat_clr = we_i && csr_hit && (sel == CSR_STAT) && wdata_i[StatIrqBit];
  assign link_evt = link_en_o && (link_up_i != link_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_en_o <= 1'b0;
      rx_en_o   <= 1'b0;
      link_q    <= 1'b0;
      irq_q     <= 1'b0;
      acc_q     <= '0;
      drop_q    <= '0;
    end else begin
      if (ctrl_we) begin
        link_en_o <= wdata_i[CtrlLinkBit];
        rx_en_o   <= wdata_i[CtrlRxBit];
      end
      link_q <= link_up_i;
      if (link_evt)      irq_q <= 1'b1;  // set wins over clear
      else if (stat_clr) irq_q <= 1'b0;
      if (done_i) begin
        if (done_keep_i) begin
          if (acc_q != '1) acc_q <= acc_q + 1'b1;
        end else if (drop_q != '1) begin
          drop_q <= drop_q + 1'b1;
        end
      end
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i[AW-1]) begin
      rdata_o = tab_rdata_i;
    end else if (csr_hit) begin
      case (sel)
        CSR_CTRL: rdata_o[1:0] = {rx_en_o, link_en_o};
        CSR_STAT: rdata_o[1:0] = {irq_q, link_up_i};
        CSR_ACC:  rdata_o[CNT_W-1:0] = acc_q;
        default:  rdata_o[CNT_W-1:0] = drop_q;
      endcase
    end
  end

  AST_ACC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == '1) |=> (acc_q == '1)); // R9
  AST_DROP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_q == '1) |=> (drop_q == '1)); // R9
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(acc_q) && $stable(drop_q)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !stat_clr) |=> irq_q); // R8
endmodule

// File: rtl/rx_admit_filter.sv
module rx_admit_filter #(
  parameter int  ENTRIES = 16,
  parameter int  DA_W    = 48,
  parameter int  CNT_W   = 16,
  localparam int AW      = $clog2(ENTRIES) + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            link_up_i,
  input  logic [DA_W-1:0] nvm_addr_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_sof_i,
  input  logic            rx_eof_i,
  input  logic            rx_err_i,
  output logic            wr_valid_o,
  output logic [7:0]      wr_data_o,
  output logic            wr_sof_o,
  output logic            wr_last_o,
  output logic            wr_keep_o,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic            irq_o
);
  logic [ENTRIES-1:0][DA_W-1:0] tab;
  logic [ENTRIES-1:0]           val;
  logic [31:0]                  tab_rdata;
  logic                         link_en, rx_en, done, done_keep;

  rxa_addr_table #(.N(ENTRIES), .DA_W(DA_W), .AW(AW)) i_table (
    .clk_i, .rst_ni, .nvm_addr_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .tab_o(tab), .val_o(val), .rdata_o(tab_rdata)
  );

  rxa_frame #(.N(ENTRIES), .DA_W(DA_W)) i_frame (
    .clk_i, .rst_ni, .en_i(link_en && rx_en), .tab_i(tab), .val_i(val),
    .rx_valid_i, .rx_data_i, .rx_sof_i, .rx_eof_i, .rx_err_i,
    .wr_valid_o, .wr_data_o, .wr_sof_o, .wr_last_o, .wr_keep_o,
    .done_o(done), .done_keep_o(done_keep)
  );

  rxa_csr #(.CNT_W(CNT_W), .AW(AW)) i_csr (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[1:0]), .tab_rdata_i(tab_rdata), .link_up_i,
    .done_i(done), .done_keep_i(done_keep),
    .link_en_o(link_en), .rx_en_o(rx_en), .irq_o, .rdata_o(reg_rdata_o)
  );

  AST_GATE_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_sof_o) |-> $past(link_en)); // R1
  AST_GATE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_sof_o) |-> $past(rx_en)); // R2
endmodule

// File: tb/test_rx_admit_filter.sv
module test_rx_admit_filter;
  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic [47:0] nvm = 48'h02AA_BBCC_DD01;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic [7:0]  rx_data = '0;
  logic        wr_valid, wr_sof, wr_last, wr_keep, irq;
  logic [7:0]  wr_data;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int    checks = 0, errors = 0;
  string cur_req = "R3";

  always #4 clk = ~clk;

  rx_admit_filter #(.CNT_W(4)) i_rx_admit_filter (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link_up), .nvm_addr_i(nvm),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_err_i(rx_err),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_sof_o(wr_sof),
    .wr_last_o(wr_last), .wr_keep_o(wr_keep),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // reference model
  logic [47:0] m_tab[16];
  logic [15:0] m_val;
  logic [47:0] m_hdr;
  bit   m_slu, m_rxen, m_boot, m_irq, m_lprev, m_in, m_adm, m_err;
  bit   m_pend, m_pkeep;
  int   m_cnt, m_acc, m_drop;
  bit   e_valid, e_sof, e_last, e_keep;
  logic [7:0] e_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_tab[i] = '0;
      m_val = '0; m_hdr = '0;
      m_slu = 0; m_rxen = 0; m_boot = 1; m_irq = 0; m_lprev = 0;
      m_in = 0; m_adm = 0; m_err = 0; m_pend = 0; m_pkeep = 0;
      m_cnt = 0; m_acc = 0; m_drop = 0;
      e_valid = 0; e_sof = 0; e_last = 0; e_keep = 0; e_data = '0;
    end else begin
      bit k, hit, set, clr;
      if (m_pend) begin
        if (m_pkeep) begin if (m_acc < 15) m_acc++; end
        else if (m_drop < 15) m_drop++;
      end
      m_pend = 0;
      if (rx_valid && (rx_sof || m_in)) begin
        if (rx_sof) begin m_adm = m_slu && m_rxen; m_cnt = 0; m_err = 0; m_hdr = '0; end
        if (m_cnt < 6) m_hdr = {m_hdr[39:0], rx_data};
        m_cnt++;
        m_err = m_err || rx_err;
        hit = (m_hdr == '1);
        for (int i = 0; i < 16; i++) if (m_val[i] && m_tab[i] == m_hdr) hit = 1;
        k = (m_cnt >= 6) && !m_err && hit;
        e_valid = m_adm; e_data = rx_data; e_sof = rx_sof; e_last = rx_eof;
        e_keep = rx_eof && k;
        if (rx_eof) begin m_in = 0; m_pend = 1; m_pkeep = m_adm && k; end
        else m_in = 1;
      end else e_valid = 0;
      set = m_slu && (link_up != m_lprev);
      clr = reg_we && reg_addr == 6'h01 && reg_wdata[1];
      m_irq = set || (m_irq && !clr);
      m_lprev = link_up;
      if (m_boot) begin
        m_tab[0] = nvm; m_val[0] = 1; m_boot = 0;
      end else if (reg_we && reg_addr[5]) begin
        if (reg_addr[0]) begin
          m_tab[reg_addr[4:1]][47:32] = reg_wdata[15:0];
          m_val[reg_addr[4:1]] = reg_wdata[31];
        end else m_tab[reg_addr[4:1]][31:0] = reg_wdata;
      end
      if (reg_we && reg_addr == 6'h00) begin m_slu = reg_wdata[0]; m_rxen = reg_wdata[1]; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(wr_valid == e_valid, cur_req, "write strobe", 64'(wr_valid), 64'(e_valid));
      if (e_valid && wr_valid)
        chk({wr_data, wr_sof, wr_last, wr_keep} == {e_data, e_sof, e_last, e_keep},
            "R6", "write byte/flags", 64'({wr_data, wr_sof, wr_last, wr_keep}),
            64'({e_data, e_sof, e_last, e_keep}));
      chk(irq == m_irq, "R8", "irq_o", 64'(irq), 64'(m_irq));
    end
  end

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, req, $sformatf("reg 0x%0h", a), 64'(reg_rdata), 64'(exp));
  endtask

  function automatic bq_t mk(input logic [47:0] da, input int len);
    bq_t q;
    for (int k = 0; k < len; k++) q.push_back(k < 6 ? da[47-8*k -: 8] : 8'(k*7 + 1));
    return q;
  endfunction

  task automatic send(input bq_t b, input int err_at = -1,
                      input int wr_at = -1, input logic [31:0] wr_val = '0);
    for (int k = 0; k < b.size(); k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = b[k]; rx_sof = (k == 0);
      rx_eof = (k == b.size() - 1); rx_err = (k == err_at);
      reg_we = (k == wr_at); reg_addr = 6'h00; reg_wdata = wr_val;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; reg_we = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    reg_chk(6'h00, 32'h0, "R3");
    reg_chk(6'h02, 32'h0, "R9");
    reg_chk(6'h20, nvm[31:0], "R4");
    reg_chk(6'h21, {1'b1, 15'b0, nvm[47:16+16]}, "R4");
    reg_chk(6'h27, 32'h0, "R4");

    cur_req = "R1";
    send(mk(nvm, 10));
    reg_chk(6'h03, 32'd1, "R1");
    reg_wr(6'h00, 32'h2);
    send(mk(nvm, 8));
    reg_chk(6'h03, 32'd2, "R1");
    cur_req = "R2";
    reg_wr(6'h00, 32'h1);
    send(mk(nvm, 8));
    reg_chk(6'h03, 32'd3, "R2");
    reg_chk(6'h02, 32'd0, "R2");

    cur_req = "R6";
    reg_wr(6'h00, 32'h3);
    send(mk(nvm, 8));
    reg_chk(6'h02, 32'd1, "R6");
    send(mk(48'hFFFF_FFFF_FFFF, 9));
    reg_chk(6'h02, 32'd2, "R6");
    send(mk(48'h02AA_BBCC_DD99, 8));
    reg_chk(6'h03, 32'd4, "R6");
    send(mk(nvm, 4));
    reg_chk(6'h03, 32'd5, "R6");
    send(mk(nvm, 6));
    reg_chk(6'h02, 32'd3, "R6");
    send(mk(nvm, 8), 7);
    reg_chk(6'h03, 32'd6, "R6");

    cur_req = "R5";
    reg_wr(6'h2A, 32'h3344_5566);
    reg_wr(6'h2B, 32'h8000_1122);
    reg_chk(6'h2A, 32'h3344_5566, "R5");
    reg_chk(6'h2B, 32'h8000_1122, "R5");
    send(mk(48'h1122_3344_5566, 7));
    reg_chk(6'h02, 32'd4, "R5");
    reg_wr(6'h2B, 32'h0000_1122);
    send(mk(48'h1122_3344_5566, 7));
    reg_chk(6'h03, 32'd7, "R5");

    cur_req = "R7";
    send(mk(nvm, 10), -1, 3, 32'h1);
    reg_chk(6'h02, 32'd5, "R7");
    send(mk(nvm, 8));
    reg_chk(6'h03, 32'd8, "R2");
    send(mk(nvm, 10), -1, 2, 32'h3);
    reg_chk(6'h03, 32'd9, "R7");
    reg_chk(6'h02, 32'd5, "R7");

    cur_req = "R10";
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'(k); rx_eof = (k == 4);
    end
    @(negedge clk); rx_valid = 0; rx_eof = 0;
    repeat (2) @(negedge clk);
    reg_chk(6'h02, 32'd5, "R10");
    reg_chk(6'h03, 32'd9, "R10");

    cur_req = "R8";
    reg_wr(6'h00, 32'h2);
    link_up = 1;
    repeat (2) @(negedge clk);
    reg_chk(6'h01, 32'h1, "R8");
    link_up = 0;
    repeat (2) @(negedge clk);
    reg_wr(6'h00, 32'h3);
    link_up = 1;
    repeat (2) @(negedge clk);
    reg_chk(6'h01, 32'h3, "R8");
    repeat (3) @(negedge clk);
    reg_chk(6'h01, 32'h3, "R8");
    reg_wr(6'h01, 32'h2);
    reg_chk(6'h01, 32'h1, "R8");
    link_up = 0;
    repeat (2) @(negedge clk);
    reg_chk(6'h01, 32'h2, "R8");
    reg_wr(6'h01, 32'h2);
    reg_chk(6'h01, 32'h0, "R8");

    cur_req = "R9";
    for (int n = 0; n < 12; n++) send(mk(nvm, 7));
    reg_chk(6'h02, 32'd15, "R9");
    for (int n = 0; n < 8; n++) send(mk(nvm, 3));
    reg_chk(6'h03, 32'd15, "R9");
    reg_chk(6'h02, 32'd15, "R9");
    summary();
  end
endmodule